// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on an I2C/SMBus two-wire bus. It gives a bus master access to a small internal register file. SCL and SDA come in as raw pin levels and are sampled on a much faster system clock. The block drives SDA only through an open-drain enable: when that enable is high, the line is pulled low. Five pre-decoded address bits complete the slave's 7-bit address. The two most significant address bits are fixed at binary 10.

A write transfer carries a command byte and then one or two data bytes. Only the three least significant bits of the command byte are kept, and they form the register pointer. The first data byte is stored in the pointed register. A second data byte is acknowledged and then discarded. A read transfer sets the pointer with a write-direction command byte, then sends a repeated START and the read address. For as long as the master acknowledges, the block returns the pointed register again. The block also answers a broadcast write address, and it answers the Alert Response Address while an external alert controller reports an active alert. It sends that controller a one-cycle clear pulse.

Top module: `smb_reg_slave`

## Requirements
- R1: `sda_oe` is low during and after reset and in the cycle after a detected STOP (SDA rising while SCL is high). A START (SDA falling while SCL is high) restarts address reception from any state.
- R2: The slave acknowledges an address byte only when its upper 7 bits equal {2'b10, `pin_addr`}, the broadcast address or the alert address under the conditions below. Any other address is not acknowledged, and later bytes are ignored without acknowledge until the next START or STOP.
- R3: In a write, bits [2:0] of the command byte become the register pointer. The first data byte is acknowledged and stored in the register that the pointer selects.
- R4: A second data byte in a write is acknowledged but changes no register, including the next one after the pointed register.
- R5: After a repeated START with the read bit (bit 0 = 1), the slave sends the pointed register MSB first. Data changes only while SCL is low.
- R6: While the master acknowledges a read byte, the slave sends the same register again. After a not-acknowledge, it releases SDA until the next START or STOP.
- R7: Address 7'b1011111 with the write bit is accepted as a broadcast write while register 0 bit 0 is 1. Register 0 resets to 8'h01, and every other register resets to 8'h00.
- R8: While register 0 bit 0 is 0, the broadcast write address is not acknowledged.
- R9: The broadcast address with the read bit is never acknowledged.
- R10: Address 7'b0001100 with the read bit is acknowledged only while `alert_active` is high. The slave then sends {2'b10, `pin_addr`, 1'b1}.
- R11: `alert_clear` is a single-cycle pulse. It fires once when an alert-response byte ends and once when the own address is acknowledged.
- R12: `sda_oe` changes only in the cycle after a detected SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level (wired bus value) |
| pin_addr | input | 5 | Low five bits of the own slave address |
| alert_active | input | 1 | Alert output currently asserted by the alert controller |
| sda_oe | output | 1 | Pull SDA low when high |
| alert_clear | output | 1 | One-cycle request to release the alert |

## Verification
Two events can fall in one system cycle: the acknowledge decision for an address byte and the `alert_clear` pulse. Both are taken on the same synchronized SCL rising edge. The alert-response case is provoked by raising `alert_active` before an alert-address read, and the own-address case by a plain write. Each is judged by requiring an acknowledge and exactly one counted pulse per transfer. A separate monitor watches `sda_oe` throughout the run and flags any change while SCL is high. This shows that acknowledge, data drive and the release at the end of a transfer all move only during the SCL low phase.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W   = 8;
  localparam int SADDR_W  = 7;
  localparam int PIN_W    = 5;
  localparam logic [1:0]         FIXED_HI  = 2'b10;
  localparam logic [SADDR_W-1:0] BCAST_ADR = 7'b1011111;
  localparam logic [SADDR_W-1:0] ALERT_ADR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_ACKW, ST_ACK, ST_TX, ST_MACK, ST_IGN
  } bus_state_t;

  typedef enum logic [1:0] { PH_CMD, PH_D1, PH_D2 } rx_phase_t;

  typedef enum logic [1:0] { MD_OWN, MD_BCAST, MD_ALERT } xfer_mode_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         PTR_W    = 3,
  parameter int         DW       = 8,
  parameter logic [7:0] RST0     = 8'h01,
  parameter int         BCAST_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [DW-1:0]    rdata,
  output logic             bcast_en
);
  localparam int NREG = 1 << PTR_W;
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= (i == 0) ? DW'(RST0) : '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata    = mem[raddr];
  assign bcast_en = mem[0][BCAST_BIT];
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [PIN_W-1:0]  pin_addr,
  input  logic              alert_active,
  input  logic              bcast_en,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              alert_clear
);
  bus_state_t  state;
  rx_phase_t   rxph;
  xfer_mode_t  mode, md_next;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] sh, byte_in, tx_byte;
  logic              tgt_tx;
  logic [SADDR_W-1:0] a7, own_adr;
  logic rw, bcast_hit, own_hit, alert_hit, accept;

  assign byte_in   = {sh[BYTE_W-2:0], sda_s};
  assign a7        = byte_in[BYTE_W-1:1];
  assign rw        = byte_in[0];
  assign own_adr   = {FIXED_HI, pin_addr};
  assign bcast_hit = (a7 == BCAST_ADR);
  assign own_hit   = !bcast_hit && (a7 == own_adr);
  assign alert_hit = (a7 == ALERT_ADR) && rw && alert_active;
  assign accept    = (bcast_hit && !rw && bcast_en) || own_hit || alert_hit;

  always_comb begin
    if (alert_hit)      md_next = MD_ALERT;
    else if (bcast_hit) md_next = MD_BCAST;
    else                md_next = MD_OWN;
  end

  assign tx_byte = (mode == MD_ALERT) ? {own_adr, 1'b1} : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rxph        <= PH_CMD;
      mode        <= MD_OWN;
      bitcnt      <= '0;
      sh          <= '0;
      tgt_tx      <= 1'b0;
      ptr         <= '0;
      wr_en       <= 1'b0;
      wr_data     <= '0;
      sda_oe      <= 1'b0;
      alert_clear <= 1'b0;
    end else begin
      wr_en       <= 1'b0;
      alert_clear <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            sh <= byte_in;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              if (accept) begin
                state       <= ST_ACKW;
                tgt_tx      <= rw;
                rxph        <= PH_CMD;
                mode        <= md_next;
                alert_clear <= own_hit;
              end else begin
                state <= ST_IGN;
              end
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
          ST_RX: if (scl_rise) begin
            sh <= byte_in;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              state  <= ST_ACKW;
              tgt_tx <= 1'b0;
              case (rxph)
                PH_CMD: begin
                  ptr  <= byte_in[PTR_W-1:0];
                  rxph <= PH_D1;
                end
                PH_D1: begin
                  wr_en   <= 1'b1;
                  wr_data <= byte_in;
                  rxph    <= PH_D2;
                end
                default: rxph <= PH_D2;
              endcase
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (tgt_tx) begin
              sda_oe <= ~tx_byte[BYTE_W-1];
              sh     <= {tx_byte[BYTE_W-2:0], 1'b0};
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~sh[BYTE_W-1];
                sh     <= {sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: if (scl_rise) begin
            if (mode == MD_ALERT) begin
              alert_clear <= 1'b1;
              state       <= ST_IGN;
            end else if (!sda_s) begin
              state  <= ST_ACK;
              tgt_tx <= 1'b1;
            end else begin
              state <= ST_IGN;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int         PTR_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REG0_RESET  = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [PIN_W-1:0] pin_addr,
  input  logic             alert_active,
  output logic             sda_oe,
  output logic             alert_clear
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, bcast_en;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_regfile #(.PTR_W(PTR_W), .DW(BYTE_W), .RST0(REG0_RESET), .BCAST_BIT(0)) u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(ptr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data), .bcast_en(bcast_en)
  );

  smb_proto #(.PTR_W(PTR_W)) u_proto (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .pin_addr(pin_addr), .alert_active(alert_active), .bcast_en(bcast_en),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sda_oe(sda_oe), .alert_clear(alert_clear)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic alert_clear,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det
);
  assert_reset_release_R1: assert property (@(posedge clk) rst |=> !sda_oe);

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_oe_moves_low_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  assert_clear_single_R11: assert property (@(posedge clk) disable iff (rst)
    alert_clear |=> !alert_clear);
endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .alert_clear(alert_clear),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;
  localparam logic [6:0] OWN   = {2'b10, 5'h05};
  localparam logic [6:0] BCAST = 7'b1011111;
  localparam logic [6:0] ALRT  = 7'b0001100;
  // {kind[1:0], cmd, d0, d1}; kind 0 write byte, 1 write word, 2 read byte, 3 read word
  localparam int NVEC = 7;
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd0, 8'hF2, 8'h5A, 8'h00},
    {2'd2, 8'h02, 8'h5A, 8'h00},
    {2'd1, 8'h03, 8'hA5, 8'h3C},
    {2'd3, 8'h03, 8'hA5, 8'h00},
    {2'd0, 8'h07, 8'h81, 8'h00},
    {2'd3, 8'hFF, 8'h81, 8'h00},
    {2'd2, 8'h04, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, alert_act = 1'b0;
  logic sda_oe, alert_clear;
  wire  sda_line = m_sda & ~sda_oe;

  smb_reg_slave uut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
    .pin_addr(5'h05), .alert_active(alert_act),
    .sda_oe(sda_oe), .alert_clear(alert_clear)
  );

  int checks = 0, errors = 0, pulses = 0, hi_moves = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) if (rst === 1'b0 && alert_clear === 1'b1) pulses++;
  always @(negedge clk) begin
    if (rst === 1'b0 && sda_oe !== oe_prev && m_scl) hi_moves++;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    m_sda = b; tick(4);
    m_scl = 1'b1; tick(4);
    r = sda_line; tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(4);
    m_scl = 1'b1; tick(4);
    m_sda = 1'b0; tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(4);
    m_scl = 1'b1; tick(4);
    m_sda = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(v[i], r);
    bitx(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, r);
      v[i] = r;
    end
    bitx(~mack, r);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d0,
                           input logic [7:0] d1, input logic two, output logic ok);
    logic a0, a1, a2, a3;
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(cmd, a1);
    send_byte(d0, a2);
    a3 = 1'b1;
    if (two) send_byte(d1, a3);
    bus_stop();
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [7:0] cmd, input logic two,
                          output logic [7:0] v0, output logic [7:0] v1, output logic ok);
    logic a0, a1, a2;
    v0 = 8'hxx; v1 = 8'hxx;
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(cmd, a1);
    bus_start();
    send_byte({a, 1'b1}, a2);
    if (a2) begin
      recv_byte(two, v0);
      if (two) recv_byte(1'b0, v1);
    end
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic ok, ack;
    logic [7:0] v0, v1;
    logic [1:0] kind;
    int p0;
    tick(5);
    rst = 1'b0;
    tick(10);
    chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);

    reg_read(OWN, 8'h00, 1'b0, v0, v1, ok);
    chk("R7 reg0 reset value", v0, 8'h01);
    chk("R2 own address acked", {7'd0, ok}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      kind = VEC[i][25:24];
      if (kind[1] == 1'b0) begin
        reg_write(OWN, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], kind[0], ok);
        chk(kind[0] ? "R4 write word acks" : "R3 write byte acks", {7'd0, ok}, 8'h01);
      end else begin
        reg_read(OWN, VEC[i][23:16], kind[0], v0, v1, ok);
        chk("R5 read acks", {7'd0, ok}, 8'h01);
        chk((i >= 3) ? "R4 R5 read after word write / neighbour untouched" : "R3 R5 read byte",
            v0, VEC[i][15:8]);
        if (kind[0]) chk("R6 repeated byte", v1, VEC[i][15:8]);
      end
    end

    // R2: foreign address is refused and the following byte is ignored
    bus_start();
    send_byte({7'h22, 1'b0}, ack);
    chk("R2 foreign address nack", {7'd0, ack}, 8'h00);
    send_byte(8'h00, ack);
    chk("R2 byte after foreign address ignored", {7'd0, ack}, 8'h00);
    bus_stop();

    // R7: broadcast write while enabled
    reg_write(BCAST, 8'h01, 8'h77, 8'h00, 1'b0, ok);
    chk("R7 broadcast write acked", {7'd0, ok}, 8'h01);
    reg_read(OWN, 8'h01, 1'b0, v0, v1, ok);
    chk("R7 broadcast data stored", v0, 8'h77);

    // R9: broadcast address with read bit
    bus_start();
    send_byte({BCAST, 1'b1}, ack);
    bus_stop();
    chk("R9 broadcast read nack", {7'd0, ack}, 8'h00);

    // R8: disable broadcast, then try it
    reg_write(OWN, 8'h00, 8'h00, 8'h00, 1'b0, ok);
    bus_start();
    send_byte({BCAST, 1'b0}, ack);
    bus_stop();
    chk("R8 disabled broadcast nack", {7'd0, ack}, 8'h00);
    reg_read(OWN, 8'h01, 1'b0, v0, v1, ok);
    chk("R8 register unchanged", v0, 8'h77);

    // R10/R11: alert response
    bus_start();
    send_byte({ALRT, 1'b1}, ack);
    bus_stop();
    chk("R10 alert address nack while inactive", {7'd0, ack}, 8'h00);
    alert_act = 1'b1;
    p0 = pulses;
    bus_start();
    send_byte({ALRT, 1'b1}, ack);
    chk("R10 alert address acked while active", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, v0);
    bus_stop();
    chk("R10 alert response byte", v0, {OWN, 1'b1});
    chk("R11 one pulse per alert response", 8'(pulses - p0), 8'd1);
    alert_act = 1'b0;

    p0 = pulses;
    reg_write(OWN, 8'h02, 8'h33, 8'h00, 1'b0, ok);
    chk("R11 one pulse per own address", 8'(pulses - p0), 8'd1);

    tick(4);
    chk("R1 released after stop", {7'd0, sda_oe}, 8'h00);
    chk("R12 sda_oe never moved with SCL high", 8'(hi_moves), 8'd0);
    finish_run();
  end
endmodule